// File: doc/BRIEF.md
# SM4 Byte-Slice Round Unit

This unit executes the two scalar SM4 instructions of a processor pipeline: one serves the cipher rounds (both encryption and decryption) and the other serves key expansion. Each operation takes a single byte of the second source operand and passes it through the SM4 substitution box. It then spreads the substituted byte over a 32-bit word using the linear diffusion that belongs to the chosen operation. The word is rotated back to the byte lane it came from and XORed into the low word of the first source operand. Software issues four such operations, one per byte lane, to build one full SM4 round or one key-schedule step.

The issuing stage presents a valid strobe, the 32-bit instruction word, both source operands and a flag that says whether the SM4 extension is enabled. One cycle later the unit returns either a result sign-extended to the register width or an illegal-instruction indication. Instruction words that are not one of the two SM4 encodings produce no response.

Top module: `sm4_slice_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid` and `out_illegal` are 0 and `result` is 0. This holds even when a legal operation is presented during reset.
- R2: An operation matches only when `instr[6:0]` = 0110011, `instr[14:12]` = 000 and `instr[29:25]` is either 11000 (cipher round) or 11010 (key expansion). Any other word, including neighbouring values 11001 and 11011 in `instr[29:25]`, raises neither output flag and leaves `result` unchanged. Register-index fields `instr[24:15]` and `instr[11:7]` have no effect.
- R3: The lane index `bs` is `instr[31:30]`. The substitution input is `rs2[8*bs+7 : 8*bs]`, and the substitution is the standard SM4 S-box, so that S(0x00) = 0xD6, S(0x01) = 0x90 and S(0xFF) = 0x48.
- R4: In a cipher-round operation with b the zero-extended S-box output, the diffused word is b ^ (b<<2) ^ (b<<8) ^ (b<<18) ^ ((b&0xC0)<<10) ^ ((b&0x3F)<<26), truncated to 32 bits.
- R5: In a key-expansion operation, the diffused word is b ^ ((b&0xFE)<<7) ^ ((b&0xF8)<<13) ^ ((b&0x01)<<23) ^ ((b&0x07)<<29), truncated to 32 bits.
- R6: The diffused word is rotated left by 8*bs bits. When bs = 0 it passes through unrotated, and a rotation by 32 never occurs.
- R7: The rotated word is XORed with `rs1[31:0]`, and bit 31 of the outcome is copied into every bit of `result` above bit 31. Bits of `rs1` and `rs2` above bit 31 have no effect.
- R8: A matching word presented while `ext_en` is 0 sets `out_illegal` to 1 one cycle later, with `out_valid` at 0 and `result` unchanged. `out_valid` and `out_illegal` are never 1 together.
- R9: A matching word with `ext_en` at 1 sets `out_valid` to 1 and loads `result` exactly one cycle after it is presented. With `in_valid` at 0 the next cycle shows both flags at 0. Operations can be issued on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| rs1 | input | XLEN | First source operand (accumulator) |
| rs2 | input | XLEN | Second source operand (byte source) |
| ext_en | input | 1 | SM4 extension enabled |
| out_valid | output | 1 | `result` was loaded by a legal operation on the previous cycle |
| out_illegal | output | 1 | A matching word was refused on the previous cycle |
| result | output | XLEN | Sign-extended result of the last legal operation |

## Verification
Two behaviours share the output register in one cycle: the result of a legal operation being presented, and a refused or non-matching word on the very next issue slot that must leave that result in place. The bench drives these back to back with no idle cycle, mixing legal operations, words refused because the extension is off, and near-miss encodings. The scoreboard judges every cycle on the flag pair and the held result together, so a design that clears or reloads the result on the second behaviour fails.

// File: rtl/sm4_slice_pkg.sv
package sm4_slice_pkg;

  // Encoding fields of the two operations
  localparam logic [6:0] OPC_REGREG  = 7'b0110011;
  localparam logic [2:0] F3_SM4      = 3'b000;
  localparam logic [4:0] F5_CIPHER   = 5'b11000;
  localparam logic [4:0] F5_KEYEXP   = 5'b11010;

  // Field algebra of the substitution box
  localparam logic [7:0] GF_POLY_LO  = 8'hF5;  // x^8 + x^7 + x^6 + x^5 + x^4 + x^2 + 1
  localparam logic [7:0] AFF_ROW     = 8'hA7;  // first row of the circulant matrix
  localparam logic [7:0] AFF_CONST   = 8'hD3;
  localparam int         SBOX_DEPTH  = 256;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_CIPHER = 2'd1,
    OP_KEYEXP = 2'd2
  } sm4_op_e;

  typedef struct packed {
    logic    legal;
    logic    illegal;
    sm4_op_e op;
    logic [1:0] bsel;
  } sm4_dec_t;

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[7] ? ({sh[6:0], 1'b0} ^ GF_POLY_LO) : {sh[6:0], 1'b0};
    end
    return acc;
  endfunction

  // x^254 is the multiplicative inverse, with 0 mapping to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] x);
    logic [7:0] pw;
    logic [7:0] r;
    pw = x;
    r  = 8'h01;
    for (int i = 1; i < 8; i++) begin
      pw = gf_mul(pw, pw);
      r  = gf_mul(r, pw);
    end
    return r;
  endfunction

  function automatic logic [7:0] affine(input logic [7:0] v);
    logic [7:0] m;
    logic [7:0] o;
    m = AFF_ROW;
    o = '0;
    for (int k = 0; k < 8; k++) begin
      o[k] = ^(m & v);
      m    = {m[6:0], m[7]};
    end
    return o ^ AFF_CONST;
  endfunction

  function automatic logic [SBOX_DEPTH-1:0][7:0] build_sbox();
    logic [SBOX_DEPTH-1:0][7:0] t;
    for (int i = 0; i < SBOX_DEPTH; i++) begin
      t[i] = affine(gf_inv(affine(i[7:0])));
    end
    return t;
  endfunction

endpackage

// File: rtl/sm4_slice_decode.sv
module sm4_slice_decode
  import sm4_slice_pkg::*;
(
  input  logic        in_valid,
  input  logic [31:0] instr,
  input  logic        ext_en,
  output sm4_dec_t    dec
);

  logic match_base;
  logic unused_fields;

  assign match_base = in_valid
                   && (instr[6:0]   == OPC_REGREG)
                   && (instr[14:12] == F3_SM4);

  // Register-index fields are resolved by the register file, not here
  assign unused_fields = ^{instr[24:15], instr[11:7]};

  always_comb begin
    dec      = '0;
    dec.op   = OP_NONE;
    dec.bsel = instr[31:30];
    if (match_base) begin
      if (instr[29:25] == F5_CIPHER)      dec.op = OP_CIPHER;
      else if (instr[29:25] == F5_KEYEXP) dec.op = OP_KEYEXP;
    end
    if (dec.op != OP_NONE) begin
      dec.legal   = ext_en;
      dec.illegal = !ext_en;
    end
  end

  // R8
  always_comb begin
    legal_excl_chk: assert ($onehot0({dec.legal, dec.illegal}));
  end

endmodule

// File: rtl/sm4_slice_sbox.sv
module sm4_slice_sbox
  import sm4_slice_pkg::*;
(
  input  logic [7:0] addr,
  output logic [7:0] data
);

  // Table is evaluated at elaboration; maps onto a 256x8 ROM
  localparam logic [SBOX_DEPTH-1:0][7:0] ROM = build_sbox();

  assign data = ROM[addr];

endmodule

// File: rtl/sm4_slice_diffuse.sv
module sm4_slice_diffuse
  import sm4_slice_pkg::*;
#(
  parameter int WORD = 32
) (
  input  sm4_op_e                    op,
  input  logic [$clog2(WORD/8)-1:0]  bsel,
  input  logic [7:0]                 sb,
  output logic [WORD-1:0]            lin,
  output logic [WORD-1:0]            rot
);

  localparam int LANES = WORD / 8;

  logic [WORD-1:0] b;
  assign b = {{(WORD-8){1'b0}}, sb};

  always_comb begin
    case (op)
      OP_KEYEXP: lin = b
                     ^ ((b & 32'h0000_00FE) << 7)
                     ^ ((b & 32'h0000_00F8) << 13)
                     ^ ((b & 32'h0000_0001) << 23)
                     ^ ((b & 32'h0000_0007) << 29);
      default:   lin = b
                     ^ (b << 2)
                     ^ (b << 8)
                     ^ (b << 18)
                     ^ ((b & 32'h0000_00C0) << 10)
                     ^ ((b & 32'h0000_003F) << 26);
    endcase
  end

  // One fixed rotation per lane; the lane index only selects among them
  logic [LANES-1:0][WORD-1:0] rot_opts;

  for (genvar g = 0; g < LANES; g++) begin : g_rot
    if (g == 0) begin : g_pass
      assign rot_opts[g] = lin;
    end else begin : g_turn
      assign rot_opts[g] = {lin[WORD-1-8*g:0], lin[WORD-1:WORD-8*g]};
    end
  end

  assign rot = rot_opts[bsel];

endmodule

// File: rtl/sm4_slice_unit.sv
module sm4_slice_unit
  import sm4_slice_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] rs1,
  input  logic [XLEN-1:0] rs2,
  input  logic            ext_en,
  output logic            out_valid,
  output logic            out_illegal,
  output logic [XLEN-1:0] result
);

  localparam int WORD  = 32;
  localparam int LANES = WORD / 8;
  localparam int SEL_W = $clog2(LANES);

  sm4_dec_t dec;

  sm4_slice_decode u_decode (
    .in_valid (in_valid),
    .instr    (instr),
    .ext_en   (ext_en),
    .dec      (dec)
  );

  // Lane selection from the low word of rs2
  logic [LANES-1:0][7:0] rs2_lanes;
  logic [7:0]            sbox_in;
  logic [7:0]            sbox_out;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rs2_lanes[g] = rs2[8*g +: 8];
  end

  assign sbox_in = rs2_lanes[dec.bsel[SEL_W-1:0]];

  sm4_slice_sbox u_sbox (
    .addr (sbox_in),
    .data (sbox_out)
  );

  logic [WORD-1:0] lin_word;
  logic [WORD-1:0] rot_word;

  sm4_slice_diffuse #(.WORD(WORD)) u_diffuse (
    .op   (dec.op),
    .bsel (dec.bsel[SEL_W-1:0]),
    .sb   (sbox_out),
    .lin  (lin_word),
    .rot  (rot_word)
  );

  logic [WORD-1:0] mix_word;
  logic [XLEN-1:0] ext_word;

  assign mix_word = rot_word ^ rs1[WORD-1:0];

  if (XLEN > WORD) begin : g_sext
    logic unused_hi;
    assign unused_hi = ^{rs1[XLEN-1:WORD], rs2[XLEN-1:WORD]};
    assign ext_word  = {{(XLEN-WORD){mix_word[WORD-1]}}, mix_word};
  end else begin : g_flat
    assign ext_word = mix_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      result      <= '0;
    end else begin
      out_valid   <= dec.legal;
      out_illegal <= dec.illegal;
      if (dec.legal) result <= ext_word;
    end
  end

  // R9
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_illegal));

  // R8
  illegal_cause_chk: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> (!$past(ext_en) && $past(in_valid)));

  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(result));

  // R6
  lane0_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (dec.op != OP_NONE && dec.bsel == 2'd0) |-> (rot_word == lin_word));

  if (XLEN > WORD) begin : g_sext_chk
    // R7
    sext_fill_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (result[XLEN-1:WORD-1] == '0 || result[XLEN-1:WORD-1] == '1));
  end

endmodule

// File: tb/sm4_slice_unit_tb.sv
module sm4_slice_unit_tb;

  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst;
  logic            in_valid;
  logic [31:0]     instr;
  logic [XLEN-1:0] rs1;
  logic [XLEN-1:0] rs2;
  logic            ext_en;
  logic            out_valid;
  logic            out_illegal;
  logic [XLEN-1:0] result;

  always #4 clk = ~clk;  // 125 MHz

  sm4_slice_unit #(.XLEN(XLEN)) u_dut (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .instr       (instr),
    .rs1         (rs1),
    .rs2         (rs2),
    .ext_en      (ext_en),
    .out_valid   (out_valid),
    .out_illegal (out_illegal),
    .result      (result)
  );

  typedef struct packed {
    logic            v;
    logic            ill;
    logic [XLEN-1:0] res;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 0;

  logic [7:0]      ref_sbox [256];
  logic [XLEN-1:0] model_res;

  // ---------------- reference model ----------------
  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic [14:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (15'(a) << i);
    for (int j = 14; j >= 8; j--) if (p[j]) p = p ^ (15'h1F5 << (j - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] ref_aff(input logic [7:0] x);
    logic [7:0] o;
    for (int k = 0; k < 8; k++)
      o[k] = x[k] ^ x[(k+1)%8] ^ x[(k+2)%8] ^ x[(k+5)%8] ^ x[(k+7)%8];
    return o ^ 8'hD3;
  endfunction

  function automatic logic [31:0] ref_lin(input logic key, input logic [7:0] s);
    logic [31:0] b;
    b = {24'd0, s};
    if (key)
      return b ^ ((b & 32'hFE) << 7) ^ ((b & 32'hF8) << 13)
               ^ ((b & 32'h01) << 23) ^ ((b & 32'h07) << 29);
    return b ^ (b << 2) ^ (b << 8) ^ (b << 18)
             ^ ((b & 32'hC0) << 10) ^ ((b & 32'h3F) << 26);
  endfunction

  function automatic logic [XLEN-1:0] ref_finish(input logic [31:0] lin, input logic [1:0] bs,
                                                 input logic [XLEN-1:0] a);
    logic [31:0] r;
    logic [31:0] w;
    r = lin;
    for (int i = 0; i < int'(bs); i++) r = {r[23:0], r[31:24]};
    w = r ^ a[31:0];
    return {{(XLEN-32){w[31]}}, w};
  endfunction

  function automatic logic [31:0] mk(input logic [1:0] bs, input logic [4:0] f5,
                                     input logic [2:0] f3, input logic [6:0] opc);
    logic [14:0] regs;
    regs = 15'($urandom);
    return {bs, f5, regs[14:10], regs[9:5], f3, regs[4:0], opc};
  endfunction

  // ---------------- driver ----------------
  task automatic drive(input logic v, input logic [31:0] ins, input logic [XLEN-1:0] a,
                       input logic [XLEN-1:0] b, input logic en, input string tag);
    exp_t e;
    logic match;
    logic [1:0] bs;
    @(negedge clk);
    in_valid = v;
    instr    = ins;
    rs1      = a;
    rs2      = b;
    ext_en   = en;
    match = v && ins[6:0] == 7'b0110011 && ins[14:12] == 3'b000
              && (ins[29:25] == 5'b11000 || ins[29:25] == 5'b11010);
    bs    = ins[31:30];
    e.v   = match && en;
    e.ill = match && !en;
    if (e.v) model_res = ref_finish(ref_lin(ins[26], ref_sbox[b[8*bs +: 8]]), bs, a);
    e.res = model_res;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // Like drive, but the substituted byte is given literally
  task automatic drive_known(input logic key, input logic [7:0] in_byte, input logic [7:0] s_out,
                             input string tag);
    exp_t e;
    logic [31:0] ins;
    ins = mk(2'd0, key ? 5'b11010 : 5'b11000, 3'b000, 7'b0110011);
    @(negedge clk);
    in_valid = 1'b1;
    instr    = ins;
    rs1      = '0;
    rs2      = {56'd0, in_byte};
    ext_en   = 1'b1;
    model_res = ref_finish(ref_lin(key, s_out), 2'd0, '0);
    e.v = 1'b1; e.ill = 1'b0; e.res = model_res;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 32'h0, '0, '0, 1'b1, "R9 idle");
  endtask

  // ---------------- monitor ----------------
  initial begin
    exp_t  e;
    string t;
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (out_valid !== e.v || out_illegal !== e.ill || result !== e.res) begin
          n_bad++;
          $display("FAIL %s: got v=%0b ill=%0b res=%h expected v=%0b ill=%0b res=%h",
                   t, out_valid, out_illegal, result, e.v, e.ill, e.res);
        end
      end
    end
  end

  task automatic report();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic check_idle_outputs(input string tag);
    n_cmp++;
    if (out_valid !== 1'b0 || out_illegal !== 1'b0 || result !== '0) begin
      n_bad++;
      $display("FAIL %s: got v=%0b ill=%0b res=%h expected v=0 ill=0 res=0",
               tag, out_valid, out_illegal, result);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got running expected finished");
      report();
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [XLEN-1:0] a;
    logic [XLEN-1:0] b;
    for (int x = 0; x < 256; x++) begin
      logic [7:0] f;
      logic [7:0] inv;
      f   = ref_aff(x[7:0]);
      inv = 8'h00;
      if (f != 8'h00)
        for (int y = 1; y < 256; y++) if (ref_mul(f, y[7:0]) == 8'h01) inv = y[7:0];
      ref_sbox[x] = ref_aff(inv);
    end
    model_res = '0;

    // R1: reset dominates a legal request
    rst      = 1'b1;
    in_valid = 1'b1;
    instr    = mk(2'd1, 5'b11000, 3'b000, 7'b0110011);
    rs1      = 64'h1234_5678_9ABC_DEF0;
    rs2      = 64'h0F0E_0D0C_0B0A_0908;
    ext_en   = 1'b1;
    repeat (4) @(negedge clk);
    check_idle_outputs("R1 during reset");
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_idle_outputs("R1 after reset");

    // R3: known substitution values
    drive_known(1'b0, 8'h00, 8'hD6, "R3 S(00)");
    drive_known(1'b1, 8'h01, 8'h90, "R3 S(01)");
    drive_known(1'b0, 8'hFF, 8'h48, "R3 S(FF)");
    idle(1);

    // R4 R5 R6: both operations on every lane, back to back
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int n = 0; n < 12; n++) begin
          a = {$urandom, $urandom};
          b = {$urandom, $urandom};
          drive(1'b1, mk(s[1:0], m == 1 ? 5'b11010 : 5'b11000, 3'b000, 7'b0110011), a, b, 1'b1,
                m == 1 ? "R5 R6 key lanes" : "R4 R6 cipher lanes");
        end
      end
    end

    // R7: sign of the low word and ignored upper operand bits
    drive(1'b1, mk(2'd2, 5'b11000, 3'b000, 7'b0110011), 64'hDEAD_BEEF_FFFF_FFFF,
          64'hFFFF_FFFF_0000_0000, 1'b1, "R7 upper bits, sign");
    drive(1'b1, mk(2'd3, 5'b11010, 3'b000, 7'b0110011), 64'h5555_AAAA_0000_0000,
          64'h1357_9BDF_00A5_0000, 1'b1, "R7 upper bits, sign");
    drive(1'b1, mk(2'd0, 5'b11000, 3'b000, 7'b0110011), 64'h0, 64'hFFFF_FFFF_FFFF_FF00, 1'b1,
          "R7 upper bits, sign");

    // R8: extension off, interleaved with legal work
    drive(1'b1, mk(2'd1, 5'b11000, 3'b000, 7'b0110011), {$urandom, $urandom}, {$urandom, $urandom},
          1'b0, "R8 refused cipher");
    drive(1'b1, mk(2'd2, 5'b11010, 3'b000, 7'b0110011), {$urandom, $urandom}, {$urandom, $urandom},
          1'b1, "R8 legal after refusal");
    drive(1'b1, mk(2'd3, 5'b11010, 3'b000, 7'b0110011), {$urandom, $urandom}, {$urandom, $urandom},
          1'b0, "R8 refused key");
    drive(1'b1, mk(2'd0, 5'b11000, 3'b000, 7'b0110011), {$urandom, $urandom}, {$urandom, $urandom},
          1'b0, "R8 refused cipher");

    // R2: near-miss and unrelated words right after a legal result
    drive(1'b1, mk(2'd1, 5'b11000, 3'b000, 7'b0110011), {$urandom, $urandom}, {$urandom, $urandom},
          1'b1, "R2 legal before misses");
    drive(1'b1, mk(2'd1, 5'b11001, 3'b000, 7'b0110011), {$urandom, $urandom}, {$urandom, $urandom},
          1'b1, "R2 funct 11001");
    drive(1'b1, mk(2'd2, 5'b11011, 3'b000, 7'b0110011), {$urandom, $urandom}, {$urandom, $urandom},
          1'b1, "R2 funct 11011");
    drive(1'b1, mk(2'd0, 5'b11000, 3'b001, 7'b0110011), {$urandom, $urandom}, {$urandom, $urandom},
          1'b1, "R2 funct3 001");
    drive(1'b1, mk(2'd3, 5'b11010, 3'b000, 7'b0010011), {$urandom, $urandom}, {$urandom, $urandom},
          1'b1, "R2 opcode 0010011");
    drive(1'b1, mk(2'd0, 5'b11010, 3'b000, 7'b0110111), {$urandom, $urandom}, {$urandom, $urandom},
          1'b0, "R2 opcode miss with ext off");
    drive(1'b1, 32'h0000_0013, {$urandom, $urandom}, {$urandom, $urandom}, 1'b1, "R2 no-op word");

    // R9: a matching word without the strobe
    drive(1'b0, mk(2'd1, 5'b11000, 3'b000, 7'b0110011), {$urandom, $urandom}, {$urandom, $urandom},
          1'b1, "R9 strobe low");
    drive(1'b1, mk(2'd2, 5'b11000, 3'b000, 7'b0110011), {$urandom, $urandom}, {$urandom, $urandom},
          1'b1, "R9 single-cycle result");
    idle(3);

    repeat (3) @(posedge clk);
    report();
  end

endmodule